// File: doc/BRIEF.md
# Synchronous Serial Byte Port Slave

This block is the slave end of a full-duplex, byte-wide synchronous serial link. An external master supplies the port clock, an active-low access enable and a serial data line into the slave. The slave returns data on an open-drain line. A fast local clock oversamples all three port inputs through a two-flop synchronizer. A run-length filter then removes short glitches from the port clock. The filtered clock produces one-cycle rise and fall events.

While the enable is low, each rising port-clock edge launches the next transmit bit, and each falling edge captures the next receive bit. Both directions shift most significant bit first. After eight falling edges the slave pulses a receive strobe with the completed byte. It also arms itself to send the byte held in its transmit register on the next rising edge. Raising the enable at any moment abandons the access, drops any partial byte and releases the output line.

The control is a three-state machine. ST_IDLE covers the time the enable is high. ST_WAIT_RISE waits for the edge that launches a bit, and ST_WAIT_FALL waits for the edge that captures one. The transitions are: ST_IDLE to ST_WAIT_RISE when the synchronized enable goes low; ST_WAIT_RISE to ST_WAIT_FALL on a filtered rise; ST_WAIT_FALL to ST_WAIT_RISE on a filtered fall; and any state to ST_IDLE when the synchronized enable is high.

Top module: `serbyte_slave`

## Requirements
- R1: After reset, `rx_valid` is 0, `port_dout_oe` is 0, and the transmit register holds 0xFF.
- R2: When `port_en_n` goes high, `port_dout_oe` is 0 from the second local clock edge after the change, and the slave returns to ST_IDLE.
- R3: Bits on `port_din` are captured on filtered falling port-clock edges, most significant bit first. On the eighth such edge `rx_valid` is high for exactly one local cycle with the byte on `rx_data`, FILT_CYC+3 local edges after the port clock fell.
- R4: Transmit bits are launched on filtered rising port-clock edges, most significant bit first. The output changes FILT_CYC+3 local edges after the port clock rose and holds until the next rise.
- R5: `port_dout_oe` (1 = pull the line low) is 1 only while the access is active and the current transmit bit is 0. Otherwise the line is released. Between the enable going low and the first rise, the line is released.
- R6: A port-clock pulse shorter than FILT_CYC local cycles changes neither the output nor the received data, and does not advance the bit count.
- R7: Raising the enable in the middle of a byte discards the partial byte with no strobe. The next access starts again at bit 7 in both directions.
- R8: A `tx_load` pulse stores `tx_data`. The stored byte is sent from the first rising edge of the next byte. If no new load occurs, the same byte is sent again.
- R9: Several bytes can be exchanged in one access with no gap beyond one port-clock period. Each byte is strobed on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_clk | input | 1 | Port clock from the master |
| port_en_n | input | 1 | Active-low access enable from the master |
| port_din | input | 1 | Serial data from the master |
| port_dout_oe | output | 1 | 1 pulls the open-drain output low, 0 releases it |
| tx_data | input | DATA_W | Next byte to transmit |
| tx_load | input | 1 | Stores `tx_data` into the transmit register |
| rx_data | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
Each port-clock edge reaches the state machine after two synchronizer stages and FILT_CYC filter cycles. The result register then adds one more edge, so both the receive strobe and a new output bit are due exactly FILT_CYC+3 local edges after the port clock moves. A release of the enable reaches the output after two edges. The bench drives every port change on a falling local edge and counts falling edges from that point. It switches its expected output level and expected strobe on that exact count, and compares both on every cycle, so a result that arrives one cycle early or late is reported.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_RISE = 2'd1,
        ST_WAIT_FALL = 2'd2
    } sbp_state_t;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end
        assign sync_out[g] = stab_q;
    end
endmodule

// File: rtl/sbp_glitch_filter.sv
module sbp_glitch_filter #(
    parameter int FILT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out,
    output logic rise,
    output logic fall
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [CW-1:0] run_cnt;
    logic          level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_cnt <= '0;
            rise    <= 1'b0;
            fall    <= 1'b0;
        end else begin
            rise <= 1'b0;
            fall <= 1'b0;
            if (level_in == level_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_CYC - 1)) begin
                level_q <= level_in;
                run_cnt <= '0;
                rise    <= level_in;
                fall    <= !level_in;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign level_out = level_q;

    // R6
    filt_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> ($past(run_cnt) == CW'(FILT_CYC - 1)));

    // R6
    filt_edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/sbp_shift_core.sv
module sbp_shift_core
    import sbp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n_s,
    input  logic          din_s,
    input  logic          rise,
    input  logic          fall,
    input  logic [DW-1:0] tx_byte,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          dout_oe
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    sbp_state_t    state, nxt_state;
    logic [IW-1:0] bit_idx;
    logic [DW-1:0] rx_sr;
    logic [DW-1:0] tx_sr;
    logic          out_bit;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:      if (!en_n_s) nxt_state = ST_WAIT_RISE;
            ST_WAIT_RISE: if (rise)    nxt_state = ST_WAIT_FALL;
            ST_WAIT_FALL: if (fall)    nxt_state = ST_WAIT_RISE;
            default:                   nxt_state = ST_IDLE;
        endcase
        if (en_n_s) nxt_state = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            out_bit  <= 1'b1;
        end else begin
            rx_valid <= 1'b0;
            if (en_n_s) begin
                bit_idx <= '0;
                rx_sr   <= '0;
                out_bit <= 1'b1;
            end else begin
                unique case (state)
                    ST_WAIT_RISE: begin
                        if (rise) begin
                            if (bit_idx == '0) begin
                                out_bit <= tx_byte[DW-1];
                                tx_sr   <= tx_byte << 1;
                            end else begin
                                out_bit <= tx_sr[DW-1];
                                tx_sr   <= tx_sr << 1;
                            end
                        end
                    end
                    ST_WAIT_FALL: begin
                        if (fall) begin
                            rx_sr <= {rx_sr[DW-2:0], din_s};
                            if (bit_idx == IW'(DW - 1)) begin
                                bit_idx  <= '0;
                                rx_valid <= 1'b1;
                                rx_data  <= {rx_sr[DW-2:0], din_s};
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign dout_oe = (state != ST_IDLE) && !en_n_s && !out_bit;

    // R3
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3
    rx_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(fall) && $past(state) == ST_WAIT_FALL));

    // R2
    idle_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n_s |=> (state == ST_IDLE && out_bit && bit_idx == '0));

    // R4
    rise_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RISE && rise && !en_n_s) |=> (state == ST_WAIT_FALL));
endmodule

// File: rtl/serbyte_slave.sv
module serbyte_slave #(
    parameter int DATA_W   = 8,
    parameter int FILT_CYC = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_clk,
    input  logic              port_en_n,
    input  logic              port_din,
    output logic              port_dout_oe,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] sync_q;
    logic             pclk_s, en_n_s, din_s;
    logic             pclk_f, pclk_rise, pclk_fall;
    logic [DATA_W-1:0] tx_hold;

    sbp_sync #(.W(NSYNC), .RST_VAL(3'b010)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({port_clk, port_en_n, port_din}),
        .sync_out (sync_q)
    );
    assign pclk_s = sync_q[2];
    assign en_n_s = sync_q[1];
    assign din_s  = sync_q[0];

    sbp_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (pclk_s),
        .level_out (pclk_f),
        .rise      (pclk_rise),
        .fall      (pclk_fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_hold <= '1;
        else if (tx_load) tx_hold <= tx_data;
    end

    sbp_shift_core #(.DW(DATA_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n_s   (en_n_s),
        .din_s    (din_s),
        .rise     (pclk_rise),
        .fall     (pclk_fall),
        .tx_byte  (tx_hold),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .dout_oe  (port_dout_oe)
    );

    // R6
    edge_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_rise |-> pclk_f);

    // R8
    tx_hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> (tx_hold == $past(tx_data)));
endmodule

// File: tb/test_serbyte_slave.sv
`timescale 1ns/1ps
module test_serbyte_slave;
    localparam int F    = 25;
    localparam int HALF = 40;
    localparam int LAT  = F + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_clk = 1'b0;
    logic       port_en_n = 1'b1;
    logic       port_din = 1'b0;
    logic       port_dout_oe;
    logic [7:0] tx_data = 8'h00;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic model_oe = 1'b0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    serbyte_slave #(.DATA_W(8), .FILT_CYC(F)) i_serbyte_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .port_clk     (port_clk),
        .port_en_n    (port_en_n),
        .port_din     (port_din),
        .port_dout_oe (port_dout_oe),
        .tx_data      (tx_data),
        .tx_load      (tx_load),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one port-clock half period; oe switches at LAT when asked, strobe due at LAT
    task automatic half_phase(input logic lvl, input logic dbit, input bit change,
                              input logic new_oe, input bit want_rx,
                              input logic [7:0] exp_rx, input string req);
        @(negedge clk);
        port_clk = lvl;
        if (lvl) port_din = dbit;
        for (int k = 1; k <= HALF; k++) begin
            @(negedge clk);
            if (change && k == LAT) model_oe = new_oe;
            chk({req, " oe"}, port_dout_oe, model_oe);
            chk({req, " strobe"}, rx_valid, (want_rx && k == LAT) ? 1 : 0);
            if (want_rx && k == LAT) chk({req, " data"}, rx_data, exp_rx);
        end
    endtask

    task automatic glitch(input string req);
        @(negedge clk);
        port_clk = 1'b1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk({req, " glitch oe"}, port_dout_oe, model_oe);
            chk({req, " glitch strobe"}, rx_valid, 0);
        end
        port_clk = 1'b0;
        for (int k = 1; k <= HALF; k++) begin
            @(negedge clk);
            chk({req, " glitch oe"}, port_dout_oe, model_oe);
            chk({req, " glitch strobe"}, rx_valid, 0);
        end
    endtask

    task automatic send_byte(input logic [7:0] din_b, input logic [7:0] tx_b,
                             input int glitch_after, input string req);
        for (int i = 7; i >= 0; i--) begin
            half_phase(1'b1, din_b[i], 1'b1, ~tx_b[i], 1'b0, 8'h00, req);
            half_phase(1'b0, 1'b0, 1'b0, 1'b0, (i == 0), din_b, req);
            if (glitch_after == i) glitch("R6");
        end
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk);
        tx_data = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic start_access();
        @(negedge clk);
        port_en_n = 1'b0;
        for (int k = 1; k <= 48; k++) begin
            @(negedge clk);
            chk("R5 released before first rise", port_dout_oe, 0);
        end
        model_oe = 1'b0;
    endtask

    task automatic end_access();
        @(negedge clk);
        port_en_n = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 2) model_oe = 1'b0;
            chk("R2 release on enable high", port_dout_oe, model_oe);
            chk("R7 no strobe on release", rx_valid, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe after reset", port_dout_oe, 0);
        chk("R1 strobe after reset", rx_valid, 0);

        // R1: transmit register resets to 0xFF, line stays released
        start_access();
        send_byte(8'h6B, 8'hFF, -1, "R1 reset tx byte");
        end_access();

        // R3 R4 R5: basic exchange, then R9 back-to-back with R8 reload and repeat
        load_tx(8'hA5);
        start_access();
        send_byte(8'h3C, 8'hA5, -1, "R3 R4 R5 first byte");
        load_tx(8'h0F);
        send_byte(8'hC3, 8'h0F, -1, "R9 R8 second byte");
        send_byte(8'h81, 8'h0F, -1, "R8 repeated byte");
        end_access();

        // R7: abort mid-byte, then a fresh access restarts at the top bit
        load_tx(8'h5A);
        start_access();
        for (int i = 7; i >= 4; i--) begin
            half_phase(1'b1, 1'b1, 1'b1, ~tx_data[i], 1'b0, 8'h00, "R7 partial");
            half_phase(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R7 partial");
        end
        end_access();
        start_access();
        send_byte(8'h96, 8'h5A, -1, "R7 restart");
        end_access();

        // R6: glitches before a byte and between bits do not count
        load_tx(8'h00);
        start_access();
        glitch("R6");
        send_byte(8'hE7, 8'h00, 5, "R6 filtered byte");
        send_byte(8'h18, 8'h00, 0, "R6 R9 following byte");
        end_access();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule